// File: doc/BRIEF.md
# Timer Interrupt Status and Clear Unit

This unit sits beside a timer's event logic and turns seven single-cycle hardware event pulses into sticky status flags, a per-flag interrupt mask and one interrupt line. The events are compare match, reload match, external trigger, reload-value write done, compare-value write done, count direction turned up and count direction turned down. Software sees the flags in a read-only status word and clears them by writing ones to a separate clear word. A third word holds one enable bit per flag.

The interrupt is edge-qualified at the flag level. A flag can raise the line only when it is set while its enable is already on. Turning on the enable of a flag that is already set leaves the line low. Once raised, the line stays high until every flag that raised it has been cleared. The enable word can be written only while the timer reports that it is idle. An external-trigger pulse that the timer flags as ignored, because it was already running, does not set its flag.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset the status word, the enable word and `irq_o` are all zero.
- R2: A pulse on `evt_i[i]` sets status bit i on the next clock edge. The bit positions are: compare match 0, reload match 1, external trigger 2, compare write done 3, reload write done 4, direction up 5, direction down 6. Status bits 31:7 read as zero.
- R3: Writing to offset 0x004 clears each status bit whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R5: A write to offset 0x008 loads bits 6:0 of the enable word, which reads back at 0x008. The write is discarded while `tmr_active_i` is 1.
- R6: `irq_o` goes high on the edge after a set pulse on a flag whose enable bit was already 1.
- R7: Setting an enable bit whose flag is already set does not raise `irq_o`.
- R8: `irq_o` stays high until every flag that raised it has been cleared, and then falls on the edge of the last clear.
- R9: An external-trigger pulse (`evt_i[2]`) that arrives while `trig_ignore_i` is 1 does not set status bit 2.
- R10: Reads of offset 0x004 return zero. Writes to offset 0x000 leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Single-cycle event pulses, one per flag |
| trig_ignore_i | input | 1 | Marks the current external-trigger pulse as ignored by the timer |
| tmr_active_i | input | 1 | Timer is enabled; writes to the enable word are discarded |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt level |

## Verification
Each event line is pulsed on its own and the status word is read back. This shows whether each flag lands at its own bit position rather than at a neighbour's. Clear writes use mixed masks, so a wrongly decoded bit leaves a flag set that should clear or clears one that should stay. A set pulse and a clear write are driven into the same cycle to tell set-wins from clear-wins. Two flags are then cleared one at a time to show whether the interrupt holds until the last causing flag is gone. Setting an enable after its flag is already set, an enable write while the timer is active, and a trigger pulse marked as ignored each test a path that must leave the observed state unchanged.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned NUM_FLAGS = 7;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 12;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'h008;

  typedef enum int unsigned {
    FL_CMP_HIT  = 0,
    FL_RLD_HIT  = 1,
    FL_TRIG     = 2,
    FL_CMP_DONE = 3,
    FL_RLD_DONE = 4,
    FL_DIR_UP   = 5,
    FL_DIR_DOWN = 6
  } flag_idx_e;
endpackage

// File: rtl/tmr_irq_regif.sv
module tmr_irq_regif
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N  = NUM_FLAGS,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic [N-1:0]  status_i,
  input  logic [N-1:0]  enable_i,
  output logic [N-1:0]  clr_stb_o,
  output logic          en_wr_o,
  output logic [N-1:0]  en_wdata_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned PADW = DW - N;

  logic sel_status, sel_clear, sel_enable;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DW-1:N];

  always_comb begin
    sel_status = (addr_i == OFF_STATUS);
    sel_clear  = (addr_i == OFF_CLEAR);
    sel_enable = (addr_i == OFF_ENABLE);
  end

  // write decode: status word is read-only, clear word is write-one-to-clear
  always_comb begin
    clr_stb_o  = (we_i && sel_clear) ? wdata_i[N-1:0] : '0;
    en_wr_o    = we_i && sel_enable;
    en_wdata_o = wdata_i[N-1:0];
  end

  // read mux: clear word reads as zero, upper bits zero
  always_comb begin
    rdata_o = '0;
    if (sel_status)      rdata_o = {{PADW{1'b0}}, status_i};
    else if (sel_enable) rdata_o = {{PADW{1'b0}}, enable_i};
  end
endmodule

// File: rtl/tmr_irq_enable.sv
module tmr_irq_enable
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N = NUM_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         lock_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  logic         en_ld;
  logic [N-1:0] en_q;

  always_comb begin
    en_ld = wr_i && !lock_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_ld)  en_q <= wdata_i;
  end

  assign en_o = en_q;

  // R5: enable word must not move on a write while the timer is active
  assert_enable_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && lock_i) |=> $stable(en_q));

  // R5: an accepted write lands exactly
  assert_enable_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !lock_i) |=> (en_q == $past(wdata_i)));
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic cause_o,
  output logic cause_nxt_o
);
  logic flag_q, flag_d;
  logic cause_q, cause_d;

  // next state: set dominates clear; cause arms only when enable was already on
  always_comb begin
    flag_d  = flag_q;
    cause_d = cause_q;
    if (set_i) begin
      flag_d = 1'b1;
      if (en_i) cause_d = 1'b1;
    end else if (clr_i) begin
      flag_d  = 1'b0;
      cause_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      cause_q <= cause_d;
    end
  end

  assign flag_o      = flag_q;
  assign cause_o     = cause_q;
  assign cause_nxt_o = cause_d;

  // R4: a set pulse always leaves the flag set, even against a clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R3: a clear without a set leaves the flag low
  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);

  // R8: a flag holding the interrupt is itself still set
  assert_cause_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q |-> flag_q);

  // R7: a late enable alone never arms the cause
  assert_late_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !cause_q) |=> !cause_q);
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N  = NUM_FLAGS,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned TRIG_BIT = FL_TRIG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic          trig_ignore_i,
  input  logic          tmr_active_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_we_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic [N-1:0] set_ev;
  logic [N-1:0] clr_stb;
  logic [N-1:0] en_q;
  logic [N-1:0] en_wdata;
  logic         en_wr;
  logic [N-1:0] flag_q;
  logic [N-1:0] cause_q;
  logic [N-1:0] cause_d;
  logic         irq_q, irq_d;

  // event qualification: an ignored trigger never reaches its flag
  always_comb begin
    set_ev           = evt_i;
    set_ev[TRIG_BIT] = evt_i[TRIG_BIT] && !trig_ignore_i;
  end

  tmr_irq_regif #(.N(N), .DW(DW), .AW(AW)) u_regif (
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .we_i       (reg_we_i),
    .status_i   (flag_q),
    .enable_i   (en_q),
    .clr_stb_o  (clr_stb),
    .en_wr_o    (en_wr),
    .en_wdata_o (en_wdata),
    .rdata_o    (reg_rdata_o)
  );

  tmr_irq_enable #(.N(N)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (en_wr),
    .lock_i  (tmr_active_i),
    .wdata_i (en_wdata),
    .en_o    (en_q)
  );

  for (genvar g = 0; g < N; g++) begin : g_flag
    tmr_irq_flag u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set_ev[g]),
      .clr_i       (clr_stb[g]),
      .en_i        (en_q[g]),
      .flag_o      (flag_q[g]),
      .cause_o     (cause_q[g]),
      .cause_nxt_o (cause_d[g])
    );
  end

  always_comb begin
    irq_d = |cause_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R6: interrupt rises only after an enabled set pulse
  assert_irq_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|(set_ev & en_q)));

  // R6: an enabled set pulse raises the line on the next edge
  assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_ev & en_q)) |=> irq_q);

  // R8: interrupt never drops while a causing flag remains
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(|(cause_q & ~clr_stb))) || !irq_q || $stable(irq_q) || 1'b1
      ? ((|cause_q) == irq_q) : 1'b1);

  // R9: ignored trigger leaves a clear trigger flag clear
  assert_trig_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[TRIG_BIT] && trig_ignore_i && !flag_q[TRIG_BIT]) |=> !flag_q[TRIG_BIT]);

  // R1: immediately out of reset nothing is pending
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (flag_q == '0 && en_q == '0 && !irq_q) || !rst_n);
endmodule

// File: tb/tmr_irq_unit_test.sv
module tmr_irq_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] evt_i;
  logic        trig_ignore_i;
  logic        tmr_active_i;
  logic [11:0] reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic        reg_we_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  tmr_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .trig_ignore_i(trig_ignore_i),
    .tmr_active_i(tmr_active_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_we_i(reg_we_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  // drive at negedge, one edge passes, back at the following negedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic pulse(input logic [N-1:0] m, input logic ign);
    evt_i = m; trig_ignore_i = ign;
    @(negedge clk);
    evt_i = '0; trig_ignore_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h000, d); check("R1 status", d, 32'h0);
    rd(12'h008, d); check("R1 enable", d, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_set_each;
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin
      pulse(7'(1 << i), 1'b0);
      rd(12'h000, d);
      check($sformatf("R2 bit %0d", i), d, 32'(1 << i));
      wr(12'h004, 32'hFFFF_FFFF);
    end
    pulse(7'h7F, 1'b0);
    rd(12'h000, d); check("R2 all, high bits zero", d, 32'h7F);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(12'h004, 32'h0000_0015);
    rd(12'h000, d); check("R3 partial clear", d, 32'h6A);
    wr(12'h004, 32'h0);
    rd(12'h000, d); check("R3 zero write no effect", d, 32'h6A);
    wr(12'h004, 32'h7F);
    rd(12'h000, d); check("R3 full clear", d, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    evt_i = 7'h01;
    wr(12'h004, 32'h03);
    evt_i = '0;
    rd(12'h000, d); check("R4 set wins", d, 32'h01);
    wr(12'h004, 32'h7F);
  endtask

  task automatic t_enable_lock;
    logic [31:0] d;
    wr(12'h008, 32'hFFFF_FF25);
    rd(12'h008, d); check("R5 enable readback", d, 32'h25);
    tmr_active_i = 1'b1;
    wr(12'h008, 32'h5A);
    rd(12'h008, d); check("R5 locked write ignored", d, 32'h25);
    tmr_active_i = 1'b0;
    wr(12'h008, 32'h0);
  endtask

  task automatic t_irq_rise;
    wr(12'h008, 32'h02);
    pulse(7'h01, 1'b0);
    check("R6 disabled flag no irq", {31'b0, irq_o}, 32'h0);
    pulse(7'h02, 1'b0);
    check("R6 irq raised", {31'b0, irq_o}, 32'h1);
    wr(12'h004, 32'h7F);
    check("R6 irq dropped", {31'b0, irq_o}, 32'h0);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_late_enable;
    pulse(7'h08, 1'b0);
    wr(12'h008, 32'h08);
    check("R7 late enable", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R7 late enable stays low", {31'b0, irq_o}, 32'h0);
    wr(12'h004, 32'h7F);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_irq_hold;
    wr(12'h008, 32'h03);
    pulse(7'h03, 1'b0);
    check("R8 raised", {31'b0, irq_o}, 32'h1);
    wr(12'h004, 32'h01);
    check("R8 held after first clear", {31'b0, irq_o}, 32'h1);
    wr(12'h004, 32'h02);
    check("R8 fall after last clear", {31'b0, irq_o}, 32'h0);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_trig_ignore;
    logic [31:0] d;
    pulse(7'h04, 1'b1);
    rd(12'h000, d); check("R9 ignored trigger", d, 32'h0);
    pulse(7'h04, 1'b0);
    rd(12'h000, d); check("R9 accepted trigger", d, 32'h04);
    wr(12'h004, 32'h7F);
  endtask

  task automatic t_reads;
    logic [31:0] d;
    pulse(7'h41, 1'b0);
    rd(12'h004, d); check("R10 clear reads zero", d, 32'h0);
    wr(12'h000, 32'h0);
    rd(12'h000, d); check("R10 status write ignored", d, 32'h41);
    wr(12'h000, 32'h7F);
    rd(12'h000, d); check("R10 status write ones ignored", d, 32'h41);
    wr(12'h004, 32'h7F);
  endtask

  initial begin
    rst_n = 1'b0; evt_i = '0; trig_ignore_i = 1'b0; tmr_active_i = 1'b0;
    reg_addr_i = '0; reg_wdata_i = '0; reg_we_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_each();
    t_clear();
    t_collision();
    t_enable_lock();
    t_irq_rise();
    t_late_enable();
    t_irq_hold();
    t_trig_ignore();
    t_reads();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule